// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block keeps, for a single processor, a record of the best pending interrupt: its number, its 8-bit priority and its group class. Eligibility is computed outside and arrives as one bit per interrupt. A second bit vector says whether each interrupt has a valid target, and a flattened bus carries the priority and the group of every interrupt. The block walks the interrupt numbers one per clock and compares each eligible, targeted candidate against the record.

Two operations are offered. A full rescan marks the record idle (priority 0xFF) and walks every interrupt number. A range update walks only the numbers from `range_lo` to `range_hi` and keeps the earlier record when nothing in the range beats it. The earlier winner may lie inside that range and go unbeaten, for example because its priority was weakened or it stopped being eligible. In that case another interrupt may now be best, so the block goes straight on to a full rescan without further requests. A one-cycle `done` pulse marks the end of every operation, and `busy` is high while a walk is in progress.

Top module: `hppi_sel`

## Requirements
- R1: A candidate whose priority value is numerically lower than the recorded priority replaces the record.
- R2: When a candidate has the same priority as the record, it replaces the record only if its interrupt number is lower than or equal to the recorded number, so the lowest number wins among equals.
- R3: A candidate equal to the record in both number and priority counts as a win. A range update that re-examines the unchanged winner therefore finishes without a fallback rescan.
- R4: A recorded priority of 0xFF means no interrupt is pending. A full rescan that finds no eligible, targeted interrupt reports priority 0xFF.
- R5: A full rescan sets the recorded priority to 0xFF in the cycle after the start is taken. It then examines all NUM_IRQ interrupt numbers, from 0 upward.
- R6: When a range update finds no better candidate, the record is kept unchanged if it was idle (0xFF) or if its interrupt number lies outside the scanned range.
- R7: When a range update finds no better candidate and the previous winner's number lies inside the scanned range, the block performs a full rescan immediately. `done` is not pulsed between the two walks.
- R8: An interrupt whose target bit is 0 is never recorded, whatever its priority.
- R9: One interrupt number is examined per clock. `done` is high for exactly one cycle, N clock edges after the edge that takes `start`, where N is the number of indices scanned (N + NUM_IRQ when a fallback occurs).
- R10: `busy` is high from the edge that takes `start` until `done` rises. A `start` seen while `busy` is high is ignored.
- R11: The group class of an interrupt (GRP_W bits at `grp_flat[i*GRP_W +: GRP_W]`) is latched into `best_grp` in the same cycle that interrupt becomes the recorded winner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation. Taken only while idle |
| full_scan | input | 1 | 1 selects a full rescan, 0 a range update. Sampled with `start` |
| range_lo | input | IDX_W | First interrupt number of a range update |
| range_hi | input | IDX_W | Last interrupt number of a range update (inclusive) |
| eligible | input | NUM_IRQ | Bit i set when interrupt i is eligible |
| routed | input | NUM_IRQ | Bit i set when interrupt i has a valid target |
| prio_flat | input | NUM_IRQ*PRIO_W | Priority of interrupt i at `[i*PRIO_W +: PRIO_W]` |
| grp_flat | input | NUM_IRQ*GRP_W | Group class of interrupt i at `[i*GRP_W +: GRP_W]` |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| best_idx | output | IDX_W | Recorded winning interrupt number |
| best_prio | output | PRIO_W | Recorded winning priority, 0xFF when none |
| best_grp | output | GRP_W | Group class of the recorded winner |

## Verification
A wrong record stays wrong until the next operation touches it. The error therefore appears on `best_idx`, `best_prio` or `best_grp` in the cycle `done` rises. A broken tie-break shows up whenever two interrupts share a priority, and a broken equal-win rule shows up when an unchanged winner is re-scanned. A missed or spurious fallback changes no value in many cases, but it moves the `done` pulse by exactly NUM_IRQ cycles, so the start-to-done latency is measured on every operation.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

endpackage

// File: rtl/hps_cand_pick.sv
module hps_cand_pick #(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8,
    parameter int GRP_W   = 2,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        eligible,
    input  logic [NUM_IRQ-1:0]        routed,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IRQ*GRP_W-1:0]  grp_flat,
    input  logic [IDX_W-1:0]          sel,
    output logic                      cand_ok,
    output logic [PRIO_W-1:0]         cand_prio,
    output logic [GRP_W-1:0]          cand_grp
);

    logic [PRIO_W-1:0] prio_arr [NUM_IRQ];
    logic [GRP_W-1:0]  grp_arr  [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
        assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
        assign grp_arr[g]  = grp_flat[g*GRP_W +: GRP_W];
    end

    // An interrupt with no valid target is never offered (R8).
    assign cand_ok   = eligible[sel] & routed[sel];
    assign cand_prio = prio_arr[sel];
    assign cand_grp  = grp_arr[sel];

endmodule

// File: rtl/hps_better.sv
module hps_better #(
    parameter int PRIO_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  cand_idx,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [IDX_W-1:0]  rec_idx,
    input  logic [PRIO_W-1:0] rec_prio,
    output logic              better
);

    // Lower value wins (R1); equal value goes to the lower or same number (R2, R3).
    always_comb begin
        better = (cand_prio < rec_prio) ||
                 ((cand_prio == rec_prio) && (cand_idx <= rec_idx));
    end

endmodule

// File: rtl/hppi_sel.sv
module hppi_sel
    import hps_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8,
    parameter int GRP_W   = 2,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      full_scan,
    input  logic [IDX_W-1:0]          range_lo,
    input  logic [IDX_W-1:0]          range_hi,
    input  logic [NUM_IRQ-1:0]        eligible,
    input  logic [NUM_IRQ-1:0]        routed,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IRQ*GRP_W-1:0]  grp_flat,
    output logic                      busy,
    output logic                      done,
    output logic [IDX_W-1:0]          best_idx,
    output logic [PRIO_W-1:0]         best_prio,
    output logic [GRP_W-1:0]          best_grp
);

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_IRQ - 1);
    localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};

    typedef struct packed {
        scan_st_e          st;
        logic              whole;
        logic              seen;
        logic [IDX_W-1:0]  cur;
        logic [IDX_W-1:0]  lo;
        logic [IDX_W-1:0]  hi;
        logic [IDX_W-1:0]  rec_idx;
        logic [PRIO_W-1:0] rec_prio;
        logic [GRP_W-1:0]  rec_grp;
        logic              done;
    } sel_state_t;

    sel_state_t s_d, s_q;

    logic              cand_ok;
    logic [PRIO_W-1:0] cand_prio;
    logic [GRP_W-1:0]  cand_grp;
    logic              cand_better;
    logic              at_last;
    logic              take_win;
    logic              seen_now;
    logic              need_full;
    logic [IDX_W-1:0]  lo_clip;
    logic [IDX_W-1:0]  hi_clip;

    hps_cand_pick #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W),
        .GRP_W   (GRP_W)
    ) u_pick (
        .eligible  (eligible),
        .routed    (routed),
        .prio_flat (prio_flat),
        .grp_flat  (grp_flat),
        .sel       (s_q.cur),
        .cand_ok   (cand_ok),
        .cand_prio (cand_prio),
        .cand_grp  (cand_grp)
    );

    hps_better #(
        .PRIO_W (PRIO_W),
        .IDX_W  (IDX_W)
    ) u_better (
        .cand_idx  (s_q.cur),
        .cand_prio (cand_prio),
        .rec_idx   (s_q.rec_idx),
        .rec_prio  (s_q.rec_prio),
        .better    (cand_better)
    );

    always_comb begin
        lo_clip = (range_lo > LAST_IDX) ? LAST_IDX : range_lo;
        hi_clip = (range_hi > LAST_IDX) ? LAST_IDX : range_hi;
        if (hi_clip < lo_clip) begin
            hi_clip = lo_clip;
        end

        at_last  = (s_q.cur == s_q.hi);
        take_win = (s_q.st == ST_SCAN) && cand_ok && cand_better;
        seen_now = s_q.seen | take_win;
        // Old winner inside the range and not re-confirmed (R6, R7).
        need_full = !s_q.whole && !seen_now && (s_q.rec_prio != PRIO_NONE) &&
                    (s_q.rec_idx >= s_q.lo) && (s_q.rec_idx <= s_q.hi);

        s_d      = s_q;
        s_d.done = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_SCAN;
                    s_d.seen = 1'b0;
                    if (full_scan) begin
                        s_d.whole    = 1'b1;
                        s_d.cur      = '0;
                        s_d.lo       = '0;
                        s_d.hi       = LAST_IDX;
                        s_d.rec_prio = PRIO_NONE;
                    end else begin
                        s_d.whole = 1'b0;
                        s_d.cur   = lo_clip;
                        s_d.lo    = lo_clip;
                        s_d.hi    = hi_clip;
                    end
                end
            end
            ST_SCAN: begin
                if (take_win) begin
                    s_d.rec_idx  = s_q.cur;
                    s_d.rec_prio = cand_prio;
                    s_d.rec_grp  = cand_grp;
                    s_d.seen     = 1'b1;
                end
                if (at_last) begin
                    if (need_full) begin
                        s_d.whole    = 1'b1;
                        s_d.seen     = 1'b0;
                        s_d.cur      = '0;
                        s_d.lo       = '0;
                        s_d.hi       = LAST_IDX;
                        s_d.rec_prio = PRIO_NONE;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end
                end else begin
                    s_d.cur = s_q.cur + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ST_IDLE;
            s_q.rec_prio <= PRIO_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st == ST_SCAN);
    assign done      = s_q.done;
    assign best_idx  = s_q.rec_idx;
    assign best_prio = s_q.rec_prio;
    assign best_grp  = s_q.rec_grp;

    // R9: the completion pulse lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a start seen mid-walk does not reload the range
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !at_last) |=> (busy && $stable(s_q.lo) && $stable(s_q.hi)));

    // R5: a full rescan begins with an idle record
    a_r5_full_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && full_scan) |=> (busy && best_prio == PRIO_NONE));

    // R1: inside a walk the recorded priority never gets worse
    a_r1_prio_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !at_last) |=> (best_prio <= $past(best_prio)));

    // R8: an untargeted index leaves the record untouched
    a_r8_skip_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !at_last && !routed[s_q.cur]) |=>
            ($stable(best_idx) && $stable(best_prio) && $stable(best_grp)));

    // R10: busy drops exactly when done rises
    a_r10_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/hppi_sel_tb.sv
module hppi_sel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_IRQ    = 64;
    localparam int PRIO_W     = 8;
    localparam int GRP_W      = 2;
    localparam int IDX_W      = 6;
    localparam int NVEC       = 11;

    typedef struct packed {
        logic [5:0] pk_irq;
        logic [7:0] pk_prio;
        logic       pk_elig;
        logic       pk_tgt;
        logic       full;
        logic [5:0] lo;
        logic [5:0] hi;
        logic [5:0] ex_idx;
        logic [7:0] ex_prio;
        logic [7:0] ex_lat;
    } vec_t;

    // Each row: change one interrupt, run one operation, expect a record and latency.
    localparam vec_t TBL [NVEC] = '{
        '{6'd10, 8'h40, 1'b1, 1'b1, 1'b1, 6'd0,  6'd63, 6'd10, 8'h40, 8'd64}, // R5 full rescan
        '{6'd20, 8'h40, 1'b1, 1'b1, 1'b0, 6'd16, 6'd31, 6'd10, 8'h40, 8'd16}, // R2 R6 higher number loses tie
        '{6'd5,  8'h40, 1'b1, 1'b1, 1'b0, 6'd0,  6'd7,  6'd5,  8'h40, 8'd8},  // R2 lower number wins tie
        '{6'd30, 8'h20, 1'b1, 1'b1, 1'b0, 6'd24, 6'd31, 6'd30, 8'h20, 8'd8},  // R1 lower value wins
        '{6'd30, 8'h60, 1'b1, 1'b1, 1'b0, 6'd24, 6'd31, 6'd5,  8'h40, 8'd72}, // R7 weakened winner
        '{6'd5,  8'h40, 1'b0, 1'b1, 1'b0, 6'd0,  6'd7,  6'd10, 8'h40, 8'd72}, // R7 winner gone
        '{6'd3,  8'h10, 1'b1, 1'b0, 1'b0, 6'd0,  6'd7,  6'd10, 8'h40, 8'd8},  // R8 no target
        '{6'd3,  8'h10, 1'b1, 1'b1, 1'b0, 6'd0,  6'd3,  6'd3,  8'h10, 8'd4},  // R8 target restored
        '{6'd3,  8'h10, 1'b1, 1'b1, 1'b0, 6'd3,  6'd3,  6'd3,  8'h10, 8'd1},  // R3 equal record wins
        '{6'd63, 8'h00, 1'b1, 1'b1, 1'b0, 6'd60, 6'd63, 6'd63, 8'h00, 8'd4},  // R9 top index
        '{6'd63, 8'h00, 1'b0, 1'b1, 1'b1, 6'd0,  6'd63, 6'd3,  8'h10, 8'd64}  // R5 full after removal
    };

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      start = 1'b0;
    logic                      full_scan = 1'b0;
    logic [IDX_W-1:0]          range_lo = '0;
    logic [IDX_W-1:0]          range_hi = '0;
    logic [NUM_IRQ-1:0]        eligible = '0;
    logic [NUM_IRQ-1:0]        routed = '1;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic [NUM_IRQ*GRP_W-1:0]  grp_flat;
    logic                      busy, done;
    logic [IDX_W-1:0]          best_idx;
    logic [PRIO_W-1:0]         best_prio;
    logic [GRP_W-1:0]          best_grp;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hppi_sel #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .GRP_W(GRP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .full_scan(full_scan),
        .range_lo(range_lo), .range_hi(range_hi), .eligible(eligible),
        .routed(routed), .prio_flat(prio_flat), .grp_flat(grp_flat),
        .busy(busy), .done(done), .best_idx(best_idx),
        .best_prio(best_prio), .best_grp(best_grp)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse start at a negedge; return edges from the taking edge until done is seen.
    task automatic run_op(input logic full, input int lo, input int hi, output int lat);
        full_scan = full;
        range_lo  = IDX_W'(lo);
        range_hi  = IDX_W'(hi);
        start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        while (!done && lat < 1000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lat;
        for (int i = 0; i < NUM_IRQ; i++) begin
            prio_flat[i*PRIO_W +: PRIO_W] = 8'h80;
            grp_flat[i*GRP_W +: GRP_W]    = GRP_W'(i % 4);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R4, R10)
        check("R10 busy after reset", int'(busy), 0);
        check("R9 done after reset", int'(done), 0);
        check("R4 idle prio after reset", int'(best_prio), 8'hFF);

        for (int v = 0; v < NVEC; v++) begin
            eligible[TBL[v].pk_irq] = TBL[v].pk_elig;
            routed[TBL[v].pk_irq]   = TBL[v].pk_tgt;
            prio_flat[TBL[v].pk_irq*PRIO_W +: PRIO_W] = TBL[v].pk_prio;
            run_op(TBL[v].full, int'(TBL[v].lo), int'(TBL[v].hi), lat);
            check($sformatf("row %0d idx (R1 R2 R7)", v), int'(best_idx), int'(TBL[v].ex_idx));
            check($sformatf("row %0d prio (R1 R2 R7)", v), int'(best_prio), int'(TBL[v].ex_prio));
            check($sformatf("row %0d grp R11", v), int'(best_grp), int'(TBL[v].ex_idx) % 4);
            check($sformatf("row %0d latency R9 R3", v), lat, int'(TBL[v].ex_lat));
            @(negedge clk);
            check($sformatf("row %0d done one cycle R9", v), int'(done), 0);
        end

        // R10: second start during a full walk is ignored
        full_scan = 1'b1;
        start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        repeat (2) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        check("R10 busy during walk", int'(busy), 1);
        full_scan = 1'b0;
        range_lo  = 6'd0;
        range_hi  = 6'd0;
        start     = 1'b1;
        @(posedge clk); lat++; @(negedge clk);
        start = 1'b0;
        while (!done && lat < 1000) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        check("R10 latency unchanged by extra start", lat, 64);
        check("R10 result of full walk", int'(best_idx), 3);
        repeat (3) @(negedge clk);
        check("R10 no second operation", int'(busy) + int'(done), 0);

        // R4: nothing eligible gives the idle record
        eligible = '0;
        run_op(1'b1, 0, 63, lat);
        check("R4 empty full rescan prio", int'(best_prio), 8'hFF);
        check("R5 empty full rescan latency", lat, 64);

        // R6: idle record survives a range update without fallback
        run_op(1'b0, 0, 7, lat);
        check("R6 idle record kept latency", lat, 8);
        check("R6 idle record prio", int'(best_prio), 8'hFF);

        // R11: new winner brings its own group
        eligible[6] = 1'b1;
        grp_flat[6*GRP_W +: GRP_W] = 2'd1;
        run_op(1'b0, 4, 7, lat);
        check("R11 group of new winner", int'(best_grp), 1);
        check("R1 winner over idle record", int'(best_idx), 6);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cyc >= 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule